// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management slave on a two-wire MDIO bus. It answers at a single fixed PHY address and exposes a handful of 16-bit MII registers. Behind them sits a larger internal register space of 64-bit entries, each located by an 8-bit page and an 8-bit register index. Software on the station side never addresses that space directly. It goes through a small indirection window instead.

To write an entry, the host enables paged access and picks a page in one MII register. It then stages the 64-bit value across four 16-bit data registers. Next it writes the I/O control register twice: first with the entry index and an idle opcode, then with the same index and the write opcode. A read follows the same pattern with the read opcode, and the result lands in the data registers. In both cases the host polls the I/O control register until the opcode field reads back as idle. The back end finishes each operation a fixed, configurable number of clock cycles after it starts.

MDC and MDIO reach the block asynchronously. Both are synchronised into the system clock, and each MDC rising edge yields one bit.

Top module: `mdio_page_bridge`

## Requirements
- R1: The slave acts only on frames whose PHY address field equals PHY_ADDR (default 5'h1E); frames to any other address never assert mdio_oe and writes in them change no register.
- R2: Frames use Clause 22 framing: at least 32 ones, start bits 0 then 1, opcode 2'b10 for read or 2'b01 for write, 5-bit PHY address and 5-bit register address MSB first, a two-bit turnaround, then 16 data bits MSB first. On a read the slave drives 0 in the second turnaround bit and then the data, and releases the line after the last data bit.
- R3: MII register 16 (access control) holds the enable flag in bit 0 and the page in bits 15:8. It reads back as {page, 7'b0, enable}.
- R4: MII register 17 (I/O control) holds the entry index in bits 15:8 and the opcode in bits 1:0, and bits 7:2 read as 0. Opcode 2'b00 is idle, 2'b01 is a write and 2'b10 is a read.
- R5: MII registers 24, 25, 26 and 27 hold data bits 15:0, 31:16, 47:32 and 63:48 and read back what was written.
- R6: Writing opcode 2'b01 while enabled keeps the opcode at 01 for OP_LATENCY clock cycles. Then the four data registers are stored to the selected (page, index) entry and the opcode reads back 00.
- R7: Writing opcode 2'b10 while enabled loads the selected entry into the data registers, and the opcode then reads back 00.
- R8: When the enable bit is clear, or the opcode is 2'b11, a write to register 17 starts no back-end operation, stores the index, and leaves the opcode reading 00.
- R9: A write to register 17 while the opcode field is non-zero is ignored entirely.
- R10: Writes to any MII register other than 16, 17 and 24 to 27 are ignored, and reads from them return 0.
- R11: An entry outside NUM_PAGES pages or REGS_PER_PAGE indices per page stores nothing on a write and reads as zero.
- R12: After reset all MII registers and entries are zero and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the station, asynchronous |
| mdio_i | input | 1 | Value seen on the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when mdio_oe is high |
| mdio_oe | output | 1 | Output enable for the MDIO pad |

## Verification
The checks assume that MDC stays at least four system clocks high and four low, so that every bit passes the synchronisers intact. They also assume that MDIO changes only while MDC is low. The bench drives the line on the low phase of an eight-clock MDC period and samples just before each rising edge, so the slave has a full half period after its last update. The checks also assume the host never abandons a frame midway. Every stimulus frame is therefore complete, and a frame to a foreign PHY address is still fully formed.

// File: rtl/mdio_bridge_pkg.sv
// Shared constants and types for the MDIO paged register bridge.
// Assumes Clause 22 framing and a 64-bit entry width split into 16-bit lanes.
package mdio_bridge_pkg;
    localparam int DATA_W    = 64;
    localparam int LANE_W    = 16;
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int PRE_LEN   = 32;

    localparam logic [4:0] MII_ACCESS = 5'd16;
    localparam logic [4:0] MII_IOCTL  = 5'd17;
    localparam logic [4:0] MII_DATA0  = 5'd24;

    localparam logic [1:0] OPC_IDLE = 2'b00;
    localparam logic [1:0] OPC_WR   = 2'b01;
    localparam logic [1:0] OPC_RD   = 2'b10;

    localparam logic [1:0] FRM_RD = 2'b10;
    localparam logic [1:0] FRM_WR = 2'b01;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_OP,
        FS_ADDR,
        FS_TA,
        FS_DATA
    } frame_state_e;
endpackage

// File: rtl/mdio_bit_sync.sv
// Brings MDC and MDIO into the system clock domain and emits one strobe per
// MDC rising edge with the MDIO value that was stable around that edge.
// Assumes MDC high and low phases each last several system clocks.
module mdio_bit_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic bit_stb,
    output logic bit_val
);
    logic mdc_s1, mdc_s2, mdc_s3;
    logic dat_s1, dat_s2;

    // Two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_s1 <= 1'b0;
            mdc_s2 <= 1'b0;
            mdc_s3 <= 1'b0;
            dat_s1 <= 1'b1;
            dat_s2 <= 1'b1;
        end else begin
            mdc_s1 <= mdc;
            mdc_s2 <= mdc_s1;
            mdc_s3 <= mdc_s2;
            dat_s1 <= mdio_i;
            dat_s2 <= dat_s1;
        end
    end

    assign bit_stb = mdc_s2 & ~mdc_s3;
    assign bit_val = dat_s2;
endmodule

// File: rtl/mdio_frame_engine.sv
// Parses Clause 22 frames bit by bit and drives read data back out.
// Emits a one-cycle write strobe after the last data bit of a write frame
// addressed to PHY_ADDR. It presents the register address of the current frame
// and latches read data from the decoder at the second turnaround bit.
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h1E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_stb,
    input  logic        bit_val,
    input  logic [15:0] rd_data,
    output logic [4:0]  reg_addr,
    output logic        wr_stb,
    output logic [15:0] wr_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int PRE_CW = $clog2(PRE_LEN + 1);

    frame_state_e      state_q;
    logic [PRE_CW-1:0] pre_cnt_q;
    logic [3:0]        bit_cnt_q;
    logic [1:0]        op_q;
    logic [9:0]        addr_sh_q;
    logic [15:0]       in_sh_q;
    logic [15:0]       out_sh_q;
    logic              rd_hit, wr_hit;

    // A frame is ours when the PHY field matches and the opcode is valid.
    assign rd_hit   = (addr_sh_q[9:5] == PHY_ADDR) && (op_q == FRM_RD);
    assign wr_hit   = (addr_sh_q[9:5] == PHY_ADDR) && (op_q == FRM_WR);
    assign reg_addr = addr_sh_q[4:0];

    // Frame sequencer: preamble count, field shifting, turnaround and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FS_PRE;
            pre_cnt_q <= '0;
            bit_cnt_q <= '0;
            op_q      <= '0;
            addr_sh_q <= '0;
            in_sh_q   <= '0;
            out_sh_q  <= '0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            mdio_o    <= 1'b0;
            mdio_oe   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (bit_stb) begin
                case (state_q)
                    FS_PRE: begin
                        if (bit_val) begin
                            if (pre_cnt_q != PRE_CW'(PRE_LEN))
                                pre_cnt_q <= pre_cnt_q + 1'b1;
                        end else if (pre_cnt_q == PRE_CW'(PRE_LEN)) begin
                            state_q <= FS_START;
                        end else begin
                            pre_cnt_q <= '0;
                        end
                    end
                    FS_START: begin
                        pre_cnt_q <= '0;
                        bit_cnt_q <= '0;
                        state_q   <= bit_val ? FS_OP : FS_PRE;
                    end
                    FS_OP: begin
                        op_q <= {op_q[0], bit_val};
                        if (bit_cnt_q == 4'd1) begin
                            bit_cnt_q <= '0;
                            state_q   <= FS_ADDR;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    FS_ADDR: begin
                        addr_sh_q <= {addr_sh_q[8:0], bit_val};
                        if (bit_cnt_q == 4'd9) begin
                            bit_cnt_q <= '0;
                            state_q   <= FS_TA;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    FS_TA: begin
                        if (bit_cnt_q == 4'd0) begin
                            bit_cnt_q <= 4'd1;
                            if (rd_hit) begin
                                mdio_oe <= 1'b1;
                                mdio_o  <= 1'b0;
                            end
                        end else begin
                            bit_cnt_q <= '0;
                            state_q   <= FS_DATA;
                            if (rd_hit) begin
                                mdio_o   <= rd_data[15];
                                out_sh_q <= {rd_data[14:0], 1'b0};
                            end
                        end
                    end
                    FS_DATA: begin
                        in_sh_q <= {in_sh_q[14:0], bit_val};
                        if (rd_hit) begin
                            if (bit_cnt_q == 4'd15) begin
                                mdio_oe <= 1'b0;
                                mdio_o  <= 1'b0;
                            end else begin
                                mdio_o   <= out_sh_q[15];
                                out_sh_q <= {out_sh_q[14:0], 1'b0};
                            end
                        end
                        if (bit_cnt_q == 4'd15) begin
                            bit_cnt_q <= '0;
                            pre_cnt_q <= '0;
                            state_q   <= FS_PRE;
                            if (wr_hit) begin
                                wr_stb  <= 1'b1;
                                wr_data <= {in_sh_q[14:0], bit_val};
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= FS_PRE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mii_window_decode.sv
// Holds the MII-visible window registers: access control, I/O control and
// the data lanes. It launches back-end operations and absorbs their results.
// Assumes the back end reports completion with a one-cycle done pulse.
module mii_window_decode
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              be_start,
    output logic              be_is_read,
    output logic [7:0]        be_page,
    output logic [7:0]        be_index,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_done,
    input  logic [DATA_W-1:0] be_rdata,
    output logic              acc_en,
    output logic [1:0]        opcode
);
    logic [7:0]        page_q;
    logic [7:0]        index_q;
    logic [DATA_W-1:0] lanes_vec;
    logic              ioctl_wr;
    logic              op_valid;

    assign ioctl_wr   = wr_stb && (reg_addr == MII_IOCTL) && (opcode == OPC_IDLE);
    assign op_valid   = (wr_data[1:0] == OPC_WR) || (wr_data[1:0] == OPC_RD);
    assign be_start   = ioctl_wr && acc_en && op_valid;
    assign be_is_read = (wr_data[1:0] == OPC_RD);
    assign be_page    = page_q;
    assign be_index   = wr_data[15:8];
    assign be_wdata   = lanes_vec;

    // Control registers: page, enable, index and the self-clearing opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            acc_en  <= 1'b0;
            index_q <= '0;
            opcode  <= OPC_IDLE;
        end else begin
            if (be_done)
                opcode <= OPC_IDLE;
            if (wr_stb && reg_addr == MII_ACCESS) begin
                page_q <= wr_data[15:8];
                acc_en <= wr_data[0];
            end
            if (ioctl_wr) begin
                index_q <= wr_data[15:8];
                opcode  <= be_start ? wr_data[1:0] : OPC_IDLE;
            end
        end
    end

    // One storage lane per 16-bit slice of the 64-bit data window.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (be_done && opcode == OPC_RD)
                lane_q <= be_rdata[i*LANE_W +: LANE_W];
            else if (wr_stb && reg_addr == 5'(int'(MII_DATA0) + i))
                lane_q <= wr_data;
        end
        assign lanes_vec[i*LANE_W +: LANE_W] = lane_q;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (reg_addr == MII_ACCESS)
            rd_data = {page_q, 7'b0, acc_en};
        else if (reg_addr == MII_IOCTL)
            rd_data = {index_q, 6'b0, opcode};
        else
            for (int i = 0; i < NUM_LANES; i++)
                if (reg_addr == 5'(int'(MII_DATA0) + i))
                    rd_data = lanes_vec[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/paged_entry_store.sv
// Paged back-end storage of 64-bit entries with a fixed operation latency.
// An operation starts on a start pulse and completes OP_LATENCY cycles later
// with a one-cycle done pulse. Out-of-range entries discard writes and read 0.
module paged_entry_store
    import mdio_bridge_pkg::*;
#(
    parameter int NUM_PAGES     = 4,
    parameter int REGS_PER_PAGE = 8,
    parameter int OP_LATENCY    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [7:0]        page,
    input  logic [7:0]        index,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = NUM_PAGES * REGS_PER_PAGE;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(OP_LATENCY + 1);

    logic [CNT_W-1:0]             cnt_q;
    logic                         rd_q;
    logic                         hit_q;
    logic [IDX_W-1:0]             idx_q;
    logic [DATA_W-1:0]            wdat_q;
    logic                         in_range;
    logic [IDX_W-1:0]             idx_calc;
    logic [DEPTH-1:0][DATA_W-1:0] ent_vec;

    assign in_range = (int'(page) < NUM_PAGES) && (int'(index) < REGS_PER_PAGE);
    assign idx_calc = IDX_W'(int'(page) * REGS_PER_PAGE + int'(index));
    assign done     = busy && (cnt_q == '0);
    assign rdata    = hit_q ? ent_vec[idx_q] : '0;

    // Operation tracker: captures the request and counts down the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            rd_q   <= 1'b0;
            hit_q  <= 1'b0;
            idx_q  <= '0;
            wdat_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt_q  <= CNT_W'(OP_LATENCY - 1);
            rd_q   <= is_read;
            hit_q  <= in_range;
            idx_q  <= in_range ? idx_calc : '0;
            wdat_q <= wdata;
        end else if (busy) begin
            if (cnt_q == '0)
                busy <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // One register per entry, updated when a write to it completes.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic [DATA_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (done && !rd_q && hit_q && idx_q == IDX_W'(e))
                ent_q <= wdat_q;
        end
        assign ent_vec[e] = ent_q;
    end
endmodule

// File: rtl/mdio_page_bridge.sv
// Top level: MDIO slave at PHY_ADDR exposing a paged 64-bit register space
// through access-control, I/O-control and data MII registers.
// Assumes MDC is much slower than clk (at least four clk per MDC phase).
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR      = 5'h1E,
    parameter int         NUM_PAGES     = 4,
    parameter int         REGS_PER_PAGE = 8,
    parameter int         OP_LATENCY    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic mdio_o,
    output logic mdio_oe
);
    logic              bit_stb, bit_val;
    logic [4:0]        reg_addr;
    logic              wr_stb;
    logic [15:0]       wr_data, rd_data;
    logic              be_start, be_is_read, be_busy, be_done;
    logic [7:0]        be_page, be_index;
    logic [DATA_W-1:0] be_wdata, be_rdata;
    logic              acc_en;
    logic [1:0]        opcode;

    mdio_bit_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_i  (mdio_i),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    mii_window_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .reg_addr   (reg_addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .be_start   (be_start),
        .be_is_read (be_is_read),
        .be_page    (be_page),
        .be_index   (be_index),
        .be_wdata   (be_wdata),
        .be_done    (be_done),
        .be_rdata   (be_rdata),
        .acc_en     (acc_en),
        .opcode     (opcode)
    );

    paged_entry_store #(
        .NUM_PAGES     (NUM_PAGES),
        .REGS_PER_PAGE (REGS_PER_PAGE),
        .OP_LATENCY    (OP_LATENCY)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (be_start),
        .is_read (be_is_read),
        .page    (be_page),
        .index   (be_index),
        .wdata   (be_wdata),
        .busy    (be_busy),
        .done    (be_done),
        .rdata   (be_rdata)
    );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
// Protocol and sequencing checks for the MDIO paged register bridge.
// Assumes synchronous active-low reset on rst_n.
module mdio_page_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       be_start,
    input logic       be_busy,
    input logic       be_done,
    input logic       acc_en,
    input logic [1:0] opcode
);
    // R2
    ta_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R8
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> acc_en);

    // R9
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_busy |-> !be_start);

    // R6
    opcode_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_busy |-> (opcode != 2'b00));

    // R7
    opcode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_done |=> (opcode == 2'b00) && !be_busy);

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !mdio_oe && !be_busy);
endmodule

bind mdio_page_bridge mdio_page_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .be_start (be_start),
    .be_busy  (be_busy),
    .be_done  (be_done),
    .acc_en   (acc_en),
    .opcode   (opcode)
);

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb;
    localparam int TB_PAGES = 4;
    localparam int TB_REGS  = 8;
    localparam int TB_LAT   = 700;
    localparam logic [4:0] OWN_PHY = 5'h1E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic m_drv = 1'b1;
    logic mdio_o, mdio_oe, mdio_line;
    int   checks = 0;
    int   errors = 0;
    int   oe_cnt = 0;
    logic [63:0] model [TB_PAGES][TB_REGS];

    always #5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : m_drv;

    mdio_page_bridge #(
        .PHY_ADDR      (OWN_PHY),
        .NUM_PAGES     (TB_PAGES),
        .REGS_PER_PAGE (TB_REGS),
        .OP_LATENCY    (TB_LAT)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_i  (mdio_line),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    always @(posedge clk) if (mdio_oe) oe_cnt <= oe_cnt + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mdc_bit(input logic b, output logic s);
        m_drv = b;
        mdc = 1'b0;
        repeat (4) @(negedge clk);
        s = mdio_line;
        mdc = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, output logic [15:0] rv, output logic ta_ok);
        logic s;
        logic [15:0] acc;
        acc = '0;
        ta_ok = 1'b1;
        for (int i = 0; i < 32; i++) mdc_bit(1'b1, s);
        mdc_bit(1'b0, s);
        mdc_bit(1'b1, s);
        mdc_bit(rd, s);
        mdc_bit(!rd, s);
        for (int i = 4; i >= 0; i--) mdc_bit(phy[i], s);
        for (int i = 4; i >= 0; i--) mdc_bit(ra[i], s);
        if (rd) begin
            mdc_bit(1'b1, s);
            mdc_bit(1'b1, s);
            ta_ok = (s == 1'b0);
            for (int i = 0; i < 16; i++) begin
                mdc_bit(1'b1, s);
                acc = {acc[14:0], s};
            end
        end else begin
            mdc_bit(1'b1, s);
            mdc_bit(1'b0, s);
            for (int i = 15; i >= 0; i--) mdc_bit(wd[i], s);
        end
        mdc_bit(1'b1, s);
        rv = acc;
    endtask

    task automatic mii_wr(input logic [4:0] ra, input logic [15:0] v);
        logic [15:0] d;
        logic t;
        frame(1'b0, OWN_PHY, ra, v, d, t);
    endtask

    task automatic mii_rd(input logic [4:0] ra, output logic [15:0] v);
        logic t;
        frame(1'b1, OWN_PHY, ra, 16'h0, v, t);
        check("R2 turnaround drive", {63'b0, t}, 64'd1);
    endtask

    task automatic wait_idle(input logic [7:0] idx);
        logic [15:0] v;
        mii_rd(5'd17, v);
        check("R6 opcode busy on first poll", {62'b0, (v[1:0] != 2'b00)}, 64'd1);
        for (int n = 0; n < 8; n++) begin
            mii_rd(5'd17, v);
            if (v[1:0] == 2'b00) break;
        end
        check("R6 R7 opcode cleared", {48'b0, v}, {48'b0, idx, 8'h00});
    endtask

    task automatic paged_write(input logic [7:0] pg, input logic [7:0] idx, input logic [63:0] val);
        mii_wr(5'd16, {pg, 8'h01});
        for (int l = 0; l < 4; l++) mii_wr(5'(24 + l), val[l*16 +: 16]);
        mii_wr(5'd17, {idx, 8'h00});
        mii_wr(5'd17, {idx, 8'h01});
        wait_idle(idx);
        if (pg < TB_PAGES && idx < TB_REGS) model[pg][idx] = val;
    endtask

    task automatic paged_read(input logic [7:0] pg, input logic [7:0] idx, output logic [63:0] val);
        logic [15:0] v;
        mii_wr(5'd16, {pg, 8'h01});
        mii_wr(5'd17, {idx, 8'h00});
        mii_wr(5'd17, {idx, 8'h02});
        wait_idle(idx);
        for (int l = 0; l < 4; l++) begin
            mii_rd(5'(24 + l), v);
            val[l*16 +: 16] = v;
        end
    endtask

    function automatic logic [63:0] expect_entry(input logic [7:0] pg, input logic [7:0] idx);
        if (pg < TB_PAGES && idx < TB_REGS) return model[pg][idx];
        return 64'h0;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [63:0] q;
        logic t;
        int seed;
        seed = $urandom(32'd9173);
        for (int p = 0; p < TB_PAGES; p++)
            for (int r = 0; r < TB_REGS; r++) model[p][r] = 64'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        check("R12 oe low after reset", {63'b0, mdio_oe}, 64'd0);
        mii_rd(5'd16, v); check("R12 access reg zero", {48'b0, v}, 64'd0);
        mii_rd(5'd17, v); check("R12 ioctl reg zero", {48'b0, v}, 64'd0);
        mii_rd(5'd27, v); check("R12 data3 zero", {48'b0, v}, 64'd0);

        // R3 access control readback masks reserved bits
        mii_wr(5'd16, 16'hA5FF);
        mii_rd(5'd16, v); check("R3 access readback", {48'b0, v}, 64'h0000_0000_0000_A501);
        // R4 ioctl reserved bits read zero
        mii_wr(5'd16, 16'h0000);
        mii_wr(5'd17, 16'h3CFC);
        mii_rd(5'd17, v); check("R4 ioctl readback", {48'b0, v}, 64'h3C00);

        // R5 data lanes
        for (int l = 0; l < 4; l++) mii_wr(5'(24 + l), 16'h1111 * 16'(l + 1) ^ 16'h0F0F);
        for (int l = 0; l < 4; l++) begin
            mii_rd(5'(24 + l), v);
            check("R5 data lane readback", {48'b0, v}, {48'b0, 16'h1111 * 16'(l + 1) ^ 16'h0F0F});
        end

        // R10 unmapped registers
        mii_wr(5'd20, 16'hBEEF);
        mii_rd(5'd20, v); check("R10 unmapped read zero", {48'b0, v}, 64'd0);
        mii_rd(5'd3, v);  check("R10 low unmapped zero", {48'b0, v}, 64'd0);
        mii_rd(5'd24, v); check("R10 data untouched", {48'b0, v}, {48'b0, 16'h1111 ^ 16'h0F0F});

        // R1 foreign PHY address
        frame(1'b0, 5'h05, 5'd24, 16'hDEAD, v, t);
        mii_rd(5'd24, v); check("R1 foreign write ignored", {48'b0, v}, {48'b0, 16'h1111 ^ 16'h0F0F});
        oe_cnt = 0;
        frame(1'b1, 5'h1D, 5'd24, 16'h0, v, t);
        check("R1 foreign read no drive", oe_cnt, 64'd0);
        check("R1 foreign read floats high", {48'b0, v}, 64'hFFFF);

        // R6 R7 directed write then read
        paged_write(8'd1, 8'd2, 64'h0123_4567_89AB_CDEF);
        paged_write(8'd3, 8'd7, 64'hFFFF_0000_FFFF_0001);
        paged_read(8'd1, 8'd2, q); check("R7 read back entry", q, expect_entry(8'd1, 8'd2));
        paged_read(8'd3, 8'd7, q); check("R7 corner entry", q, expect_entry(8'd3, 8'd7));

        // R8 disabled access does nothing
        mii_wr(5'd16, 16'h0100);
        for (int l = 0; l < 4; l++) mii_wr(5'(24 + l), 16'h5A5A);
        mii_wr(5'd17, 16'h0201);
        mii_rd(5'd17, v); check("R8 disabled opcode idle", {48'b0, v}, 64'h0200);
        mii_wr(5'd16, 16'h0101);
        mii_wr(5'd17, 16'h0203);
        mii_rd(5'd17, v); check("R8 opcode 11 idle", {48'b0, v}, 64'h0200);
        paged_read(8'd1, 8'd2, q); check("R8 entry unchanged", q, expect_entry(8'd1, 8'd2));

        // R9 ioctl write while busy is ignored
        mii_wr(5'd16, 16'h0001);
        for (int l = 0; l < 4; l++) mii_wr(5'(24 + l), 16'hC0DE + 16'(l));
        mii_wr(5'd17, 16'h0400);
        mii_wr(5'd17, 16'h0401);
        mii_wr(5'd17, 16'h0602);
        mii_rd(5'd17, v); check("R9 busy write ignored", {48'b0, v}, 64'h0400);
        model[0][4] = {16'hC0E1, 16'hC0E0, 16'hC0DF, 16'hC0DE};
        paged_read(8'd0, 8'd4, q); check("R9 first op stored", q, expect_entry(8'd0, 8'd4));

        // R11 out-of-range entries
        paged_write(8'd5, 8'd2, 64'hAAAA_BBBB_CCCC_DDDD);
        paged_read(8'd5, 8'd2, q); check("R11 bad page reads zero", q, 64'd0);
        paged_read(8'd1, 8'd9, q); check("R11 bad index reads zero", q, 64'd0);
        paged_read(8'd1, 8'd2, q); check("R11 neighbour intact", q, expect_entry(8'd1, 8'd2));

        // Random mix of paged writes and reads against the model
        for (int n = 0; n < 8; n++) begin
            logic [7:0] pg, ix;
            logic [63:0] val;
            pg  = 8'($urandom_range(0, TB_PAGES));
            ix  = 8'($urandom_range(0, TB_REGS));
            val = {$urandom(), $urandom()};
            if ($urandom_range(0, 1) == 1) begin
                paged_write(pg, ix, val);
            end else begin
                paged_read(pg, ix, q);
                check("R6 R7 R11 random read", q, expect_entry(pg, ix));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule